// File: doc/BRIEF.md
# Interlaced Video Field Capture Writer

This block takes an interlaced video byte stream, whose timing codes have already been decoded into per-byte flags, and writes each field into memory through a simple bus-master write port. Software programs one base address for odd fields and one for even fields, plus a line pitch. The block packs incoming bytes into bus words, gives each word a memory address, and queues the word together with its address in a small FIFO. It asks for the bus once enough data has built up.

Capture is armed by a level enable. It starts only at the first byte of a field, so a field is never stored part-way. At the end of a field the FIFO remainder is drained. After that the block raises a sticky field-complete interrupt flag and updates a status bit that holds the field just finished. Interrupt software uses the flag and the status bit to point the display at the buffer that has just filled, so the display alternates between the two field buffers.

Top module: `field_capture_writer`

## Requirements
- R1: A field tagged even (field identity 1) is written from `even_base` and a field tagged odd (identity 0) from `odd_base`. The base is chosen at the field's first byte.
- R2: Bytes are packed four to a 32-bit word, with the first byte in bits 7:0, and the write address rises by 4 per word. With `line_pitch` zero, lines follow each other with no gap. With a nonzero pitch, line k starts at base + k*pitch. Line lengths are whole words.
- R3: With `auto_flip` set, the field identity comes from `vid_field`. With it clear, `vid_field` is ignored: the first field after arming from idle is odd, and each completed field flips the next one.
- R4: `wr_req` is high whenever the FIFO holds at least 8 words (32 bytes). While `wr_req` is high and `wr_ack` is low, `wr_addr` and `wr_data` stay unchanged.
- R5: While armed, capture begins only on a valid byte with `vid_sof`. Bytes before that are dropped, and a field start that arrives while the previous field is still draining is missed.
- R6: After `vid_eof`, any words left below the threshold are still requested. The field counts as complete only when the FIFO is empty.
- R7: Field completion sets an interrupt flag that stays set until an `irq_clear` pulse; completion wins over a clear in the same cycle. `irq` is the flag gated by `irq_enable`.
- R8: `cur_field` gives the identity of the most recently completed field (0 odd, 1 even).
- R9: When `cap_enable` is low, no new field starts. A field already in progress still completes.
- R10: After reset `wr_req`, `irq` and `cur_field` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cap_enable | input | 1 | Arms capture at the next field start |
| auto_flip | input | 1 | Take field identity from the stream |
| irq_enable | input | 1 | Interrupt output mask |
| irq_clear | input | 1 | Write-one-to-clear pulse for the flag |
| odd_base | input | 32 | Odd field base address |
| even_base | input | 32 | Even field base address |
| line_pitch | input | 32 | Line start distance in bytes, 0 = packed |
| vid_valid | input | 1 | Video byte valid |
| vid_data | input | 8 | Video byte |
| vid_sof | input | 1 | First byte of a field |
| vid_sol | input | 1 | First byte of a line |
| vid_eof | input | 1 | End-of-field strobe |
| vid_field | input | 1 | Field identity from the decoder |
| wr_req | output | 1 | Write request, word valid |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Word accepted |
| irq | output | 1 | Field complete interrupt |
| cur_field | output | 1 | Last completed field identity |

## Verification
The hardest case to reach is a new field start that lands while the previous field is still draining. The bench holds `wr_ack` low right after an end of field, which keeps a below-threshold remainder stuck in the FIFO, and then sends a full field with its start marker. Releasing the acknowledge then shows that the missed field wrote nothing. A second hard case is telling a re-arm from plain alternation. The bench turns the enable off partway through an odd field, lets that field finish, and re-enables. The next field must then go to the odd base and not the even one.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FLUSH   = 2'd3
    } cap_state_e;
endpackage

// File: rtl/fcw_ctrl.sv
module fcw_ctrl
    import fcw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_enable,
    input  logic          auto_flip,
    input  logic          irq_clear,
    input  logic          vid_valid,
    input  logic          vid_sof,
    input  logic          vid_eof,
    input  logic          vid_field,
    input  logic          fifo_empty,
    input  logic [AW-1:0] odd_base,
    input  logic [AW-1:0] even_base,
    output cap_state_e    state,
    output logic          byte_en,
    output logic          start,
    output logic [AW-1:0] start_base,
    output logic          flushing,
    output logic          field_done,
    output logic          cap_field,
    output logic          irq_flag,
    output logic          cur_field
);
    typedef struct packed {
        cap_state_e st;
        logic       nxt_fld;
        logic       fld;
        logic       irq_flag;
        logic       cur_fld;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  sel_fld;

    always_comb begin
        ctl_d      = ctl_q;
        byte_en    = 1'b0;
        start      = 1'b0;
        field_done = 1'b0;
        sel_fld    = auto_flip ? vid_field : ctl_q.nxt_fld;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cap_enable) begin
                    ctl_d.st      = ST_ARMED;
                    ctl_d.nxt_fld = 1'b0;
                end
            end
            ST_ARMED: begin
                if (!cap_enable) begin
                    ctl_d.st = ST_IDLE;
                end else if (vid_valid && vid_sof) begin
                    ctl_d.st  = ST_CAPTURE;
                    ctl_d.fld = sel_fld;
                    start     = 1'b1;
                    byte_en   = 1'b1;
                end
            end
            ST_CAPTURE: begin
                byte_en = vid_valid;
                if (vid_eof) ctl_d.st = ST_FLUSH;
            end
            default: begin
                if (fifo_empty) begin
                    field_done    = 1'b1;
                    ctl_d.cur_fld = ctl_q.fld;
                    ctl_d.nxt_fld = ~ctl_q.fld;
                    ctl_d.st      = cap_enable ? ST_ARMED : ST_IDLE;
                end
            end
        endcase
        if (field_done)     ctl_d.irq_flag = 1'b1;
        else if (irq_clear) ctl_d.irq_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign state      = ctl_q.st;
    assign start_base = sel_fld ? even_base : odd_base;
    assign flushing   = (ctl_q.st == ST_FLUSH);
    assign cap_field  = ctl_q.fld;
    assign irq_flag   = ctl_q.irq_flag;
    assign cur_field  = ctl_q.cur_fld;
endmodule

// File: rtl/fcw_packer.sv
module fcw_packer #(
    parameter int AW        = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_en,
    input  logic                   start,
    input  logic [AW-1:0]          start_base,
    input  logic                   vid_sol,
    input  logic [7:0]             vid_data,
    input  logic [AW-1:0]          line_pitch,
    output logic                   push,
    output logic [AW-1:0]          push_addr,
    output logic [8*BUS_BYTES-1:0] push_data
);
    localparam int DW     = 8 * BUS_BYTES;
    localparam int LANE_W = $clog2(BUS_BYTES);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BUS_BYTES - 1);

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [AW-1:0]     ptr;
        logic [AW-1:0]     line;
        logic [DW-1:0]     buffer;
    } pack_t;

    pack_t             pk_d, pk_q;
    logic [AW-1:0]     eff_ptr;
    logic [AW-1:0]     line_nx;
    logic [LANE_W-1:0] lane;
    logic [DW-1:0]     wbuf;

    always_comb begin
        pk_d = pk_q;
        push = 1'b0;
        lane = start ? '0 : pk_q.lane;
        if (start) begin
            eff_ptr = start_base;
            line_nx = start_base;
        end else if (vid_sol && (line_pitch != '0)) begin
            eff_ptr = pk_q.line + line_pitch;
            line_nx = pk_q.line + line_pitch;
        end else begin
            eff_ptr = pk_q.ptr;
            line_nx = pk_q.line;
        end
        wbuf = pk_q.buffer;
        wbuf[lane*8 +: 8] = vid_data;
        if (byte_en) begin
            pk_d.line   = line_nx;
            pk_d.buffer = wbuf;
            if (lane == LAST_LANE) begin
                push      = 1'b1;
                pk_d.lane = '0;
                pk_d.ptr  = eff_ptr + AW'(BUS_BYTES);
            end else begin
                pk_d.lane = lane + 1'b1;
                pk_d.ptr  = eff_ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign push_addr = eff_ptr;
    assign push_data = wbuf;
endmodule

// File: rtl/fcw_fifo.sv
module fcw_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t        ff_d, ff_q;
    logic [W-1:0] mem [DEPTH];
    logic         wr_en;
    logic         rd_en;

    always_comb begin
        ff_d  = ff_q;
        rd_en = pop && (ff_q.cnt != '0);
        wr_en = push && ((ff_q.cnt != CNT_W'(DEPTH)) || rd_en);
        if (wr_en) ff_d.wp = (ff_q.wp == PTR_W'(DEPTH - 1)) ? '0 : ff_q.wp + 1'b1;
        if (rd_en) ff_d.rp = (ff_q.rp == PTR_W'(DEPTH - 1)) ? '0 : ff_q.rp + 1'b1;
        case ({wr_en, rd_en})
            2'b10:   ff_d.cnt = ff_q.cnt + 1'b1;
            2'b01:   ff_d.cnt = ff_q.cnt - 1'b1;
            default: ff_d.cnt = ff_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[ff_q.wp] <= din;
    end

    assign head  = mem[ff_q.rp];
    assign count = ff_q.cnt;
    assign empty = (ff_q.cnt == '0);
endmodule

// File: rtl/field_capture_writer.sv
module field_capture_writer
    import fcw_pkg::*;
#(
    parameter int AW           = 32,
    parameter int BUS_BYTES    = 4,
    parameter int THRESH_BYTES = 32,
    parameter int DEPTH        = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_enable,
    input  logic                   auto_flip,
    input  logic                   irq_enable,
    input  logic                   irq_clear,
    input  logic [AW-1:0]          odd_base,
    input  logic [AW-1:0]          even_base,
    input  logic [AW-1:0]          line_pitch,
    input  logic                   vid_valid,
    input  logic [7:0]             vid_data,
    input  logic                   vid_sof,
    input  logic                   vid_sol,
    input  logic                   vid_eof,
    input  logic                   vid_field,
    output logic                   wr_req,
    output logic [AW-1:0]          wr_addr,
    output logic [8*BUS_BYTES-1:0] wr_data,
    input  logic                   wr_ack,
    output logic                   irq,
    output logic                   cur_field
);
    localparam int DW           = 8 * BUS_BYTES;
    localparam int EW           = AW + DW;
    localparam int CNT_W        = $clog2(DEPTH + 1);
    localparam int THRESH_WORDS = THRESH_BYTES / BUS_BYTES;

    cap_state_e       cap_state;
    logic             byte_en;
    logic             start;
    logic [AW-1:0]    start_base;
    logic             flushing;
    logic             field_done;
    logic             cap_field;
    logic             irq_flag;
    logic             push;
    logic [AW-1:0]    push_addr;
    logic [DW-1:0]    push_data;
    logic [EW-1:0]    fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_empty;
    logic             pop;

    fcw_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_enable (cap_enable),
        .auto_flip  (auto_flip),
        .irq_clear  (irq_clear),
        .vid_valid  (vid_valid),
        .vid_sof    (vid_sof),
        .vid_eof    (vid_eof),
        .vid_field  (vid_field),
        .fifo_empty (fifo_empty),
        .odd_base   (odd_base),
        .even_base  (even_base),
        .state      (cap_state),
        .byte_en    (byte_en),
        .start      (start),
        .start_base (start_base),
        .flushing   (flushing),
        .field_done (field_done),
        .cap_field  (cap_field),
        .irq_flag   (irq_flag),
        .cur_field  (cur_field)
    );

    fcw_packer #(.AW(AW), .BUS_BYTES(BUS_BYTES)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (byte_en),
        .start      (start),
        .start_base (start_base),
        .vid_sol    (vid_sol),
        .vid_data   (vid_data),
        .line_pitch (line_pitch),
        .push       (push),
        .push_addr  (push_addr),
        .push_data  (push_data)
    );

    fcw_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({push_addr, push_data}),
        .pop   (pop),
        .head  (fifo_head),
        .count (fifo_count),
        .empty (fifo_empty)
    );

    assign wr_req  = (32'(fifo_count) >= THRESH_WORDS) || (flushing && !fifo_empty);
    assign pop     = wr_req && wr_ack;
    assign wr_addr = fifo_head[EW-1:DW];
    assign wr_data = fifo_head[DW-1:0];
    assign irq     = irq_flag && irq_enable;
endmodule

// File: rtl/fcw_checker.sv
module fcw_checker
    import fcw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          irq,
    input logic          irq_enable,
    input logic          irq_clear,
    input logic          cur_field,
    input cap_state_e    cap_state,
    input logic          field_done,
    input logic          cap_field,
    input logic          fifo_empty,
    input logic          vid_valid,
    input logic          vid_sof
);
    p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    p_quiet_when_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_state == ST_IDLE) || (cap_state == ST_ARMED)) |-> !wr_req);

    p_start_on_sof_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_state == ST_ARMED) && !(vid_valid && vid_sof)) |=> (cap_state != ST_CAPTURE));

    p_done_when_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |-> (fifo_empty && !wr_req));

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear && irq_enable) |=> (irq || !irq_enable));

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !field_done) |=> !irq);

    p_status_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |=> (cur_field == $past(cap_field)));
endmodule

bind field_capture_writer fcw_checker #(.AW(AW), .DW(8 * BUS_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .wr_ack     (wr_ack),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .irq        (irq),
    .irq_enable (irq_enable),
    .irq_clear  (irq_clear),
    .cur_field  (cur_field),
    .cap_state  (cap_state),
    .field_done (field_done),
    .cap_field  (cap_field),
    .fifo_empty (fifo_empty),
    .vid_valid  (vid_valid),
    .vid_sof    (vid_sof)
);

// File: tb/field_capture_writer_test.sv
`timescale 1ns/1ps
module field_capture_writer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cap_enable, auto_flip, irq_enable, irq_clear;
    logic [31:0] odd_base, even_base, line_pitch;
    logic        vid_valid, vid_sof, vid_sol, vid_eof, vid_field;
    logic [7:0]  vid_data;
    logic        wr_req, wr_ack, irq, cur_field;
    logic [31:0] wr_addr, wr_data;

    always #5 clk = ~clk;

    field_capture_writer uut (
        .clk(clk), .rst_n(rst_n), .cap_enable(cap_enable), .auto_flip(auto_flip),
        .irq_enable(irq_enable), .irq_clear(irq_clear), .odd_base(odd_base),
        .even_base(even_base), .line_pitch(line_pitch), .vid_valid(vid_valid),
        .vid_data(vid_data), .vid_sof(vid_sof), .vid_sol(vid_sol), .vid_eof(vid_eof),
        .vid_field(vid_field), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .irq(irq), .cur_field(cur_field)
    );

    int  checks = 0;
    int  fails  = 0;
    int  wcount = 0;
    int  cyc    = 0;
    bit  ack_hold = 1'b0;
    bit  fin = 1'b0;

    // behavioural reference model state
    int          mst = 0;      // 0 idle, 1 armed, 2 capturing, 3 draining
    int          mcnt = 0;
    bit          mnext = 0, mfld = 0, mirq = 0, mcur = 0;
    logic [31:0] mbase = 0, waddr = 0, wbuf = 0;
    int          lidx = 0, loff = 0, toff = 0;
    logic [63:0] expq[$];

    function automatic bit exp_req();
        return (mcnt >= 8) || (mst == 3 && mcnt > 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mcnt = 0; mnext = 0; mfld = 0; mirq = 0; mcur = 0;
            expq.delete();
        end else begin
            bit pop, cap, st, done;
            logic [31:0] a;
            pop = exp_req() && wr_ack;
            cap = 0; st = 0; done = 0;
            if (pop) begin
                wcount++;
                if (expq.size() == 0)
                    chk(0, "R4 write with nothing queued", {wr_addr, wr_data}, 64'h0);
                else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    chk({wr_addr, wr_data} === e, "R1/R2 write address and data", {wr_addr, wr_data}, e);
                end
            end
            case (mst)
                0: if (cap_enable) begin mst = 1; mnext = 0; end
                1: if (!cap_enable) mst = 0;
                   else if (vid_valid && vid_sof) begin
                       st = 1; cap = 1; mst = 2;
                       mfld = auto_flip ? vid_field : mnext;
                   end
                2: begin cap = vid_valid; if (vid_eof) mst = 3; end
                default: if (mcnt == 0) done = 1;
            endcase
            if (st) begin
                mbase = mfld ? even_base : odd_base;
                lidx = 0; loff = 0; toff = 0;
            end
            if (cap) begin
                if (vid_sol && !st) begin lidx++; loff = 0; end
                a = (line_pitch == 0) ? mbase + 32'(toff)
                                      : mbase + 32'(lidx) * line_pitch + 32'(loff);
                if (toff % 4 == 0) waddr = a;
                wbuf[(toff % 4) * 8 +: 8] = vid_data;
                toff++; loff++;
                if (toff % 4 == 0) begin
                    expq.push_back({waddr, wbuf});
                    mcnt++;
                end
            end
            if (done) begin
                mcur = mfld; mnext = !mfld; mirq = 1;
                mst = cap_enable ? 1 : 0;
            end else if (irq_clear) mirq = 0;
            if (pop) mcnt--;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(wr_req === exp_req(), "R4/R6 request level", 64'(wr_req), 64'(exp_req()));
            chk(irq === (mirq && irq_enable), "R7 interrupt output", 64'(irq), 64'(mirq && irq_enable));
            chk(cur_field === mcur, "R8 current field status", 64'(cur_field), 64'(mcur));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_n(input int n);
        vid_valid = 0; vid_sof = 0; vid_sol = 0; vid_eof = 0;
        repeat (n) tick();
    endtask

    task automatic send_field(input bit fid, input int nl, input int lb,
                              input bit with_sof, input int seed, input int dis_line);
        for (int l = 0; l < nl; l++) begin
            for (int b = 0; b < lb; b++) begin
                if (l == dis_line && b == 0) cap_enable = 0;
                vid_valid = 1;
                vid_data  = 8'(seed * 13 + l * 37 + b * 5);
                vid_sof   = with_sof && (l == 0) && (b == 0);
                vid_sol   = (b == 0);
                vid_field = fid;
                tick();
            end
        end
        vid_valid = 0; vid_sof = 0; vid_sol = 0;
        tick();
        vid_eof = 1;
        tick();
        vid_eof = 0;
    endtask

    task automatic pulse_clear();
        irq_clear = 1; tick(); irq_clear = 0;
    endtask

    initial begin
        wr_ack = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            wr_ack = !ack_hold && (cyc % 3 != 1);
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int w0;
        rst_n = 0; cap_enable = 0; auto_flip = 1; irq_enable = 1; irq_clear = 0;
        odd_base = 32'h0000_1000; even_base = 32'h0000_8000; line_pitch = 0;
        vid_valid = 0; vid_sof = 0; vid_sol = 0; vid_eof = 0; vid_field = 0; vid_data = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(wr_req === 1'b0, "R10 reset request", 64'(wr_req), 64'h0);
        chk(irq === 1'b0, "R10 reset interrupt", 64'(irq), 64'h0);
        chk(cur_field === 1'b0, "R10 reset status", 64'(cur_field), 64'h0);
        tick();

        // disabled: full field ignored
        send_field(0, 2, 16, 1, 1, -1); idle_n(20);
        chk(wcount == 0, "R9 no capture while disabled", 64'(wcount), 64'h0);

        // armed mid-field: bytes without a start marker are dropped
        cap_enable = 1; idle_n(3);
        send_field(0, 2, 16, 0, 2, -1); idle_n(20);
        chk(wcount == 0, "R5 no capture before field start", 64'(wcount), 64'h0);

        // odd field, packed lines
        w0 = wcount;
        send_field(0, 2, 16, 1, 3, -1); idle_n(60);
        chk(wcount - w0 == 8, "R2 packed field word count", 64'(wcount - w0), 64'd8);
        chk(irq === 1'b1, "R7 interrupt after field", 64'(irq), 64'h1);
        chk(cur_field === 1'b0, "R1/R8 odd field status", 64'(cur_field), 64'h0);
        pulse_clear(); idle_n(2);
        chk(irq === 1'b0, "R7 cleared by write-one", 64'(irq), 64'h0);

        // even field with pitch, remainder below threshold flushed
        line_pitch = 32'd64; w0 = wcount;
        send_field(1, 3, 12, 1, 4, -1); idle_n(60);
        chk(wcount - w0 == 9, "R6 remainder flushed", 64'(wcount - w0), 64'd9);
        chk(cur_field === 1'b1, "R1/R8 even field status", 64'(cur_field), 64'h1);

        // flag stays set, mask hides it
        send_field(0, 2, 8, 1, 5, -1); idle_n(60);
        chk(irq === 1'b1, "R7 flag stays set", 64'(irq), 64'h1);
        irq_enable = 0; idle_n(2);
        chk(irq === 1'b0, "R7 masked output", 64'(irq), 64'h0);
        irq_enable = 1; idle_n(2);
        chk(irq === 1'b1, "R7 unmasked output", 64'(irq), 64'h1);
        pulse_clear();

        // auto-flip off: stream identity ignored, alternation used
        auto_flip = 0;
        send_field(0, 2, 8, 1, 6, -1); idle_n(60);
        chk(cur_field === 1'b1, "R3 alternation gives even", 64'(cur_field), 64'h1);
        send_field(0, 2, 8, 1, 7, -1); idle_n(60);
        chk(cur_field === 1'b0, "R3 alternation gives odd", 64'(cur_field), 64'h0);

        // field start during drain is missed
        ack_hold = 1; w0 = wcount;
        send_field(1, 4, 4, 1, 8, -1); idle_n(5);
        chk(wr_req === 1'b1, "R6 drain request below threshold", 64'(wr_req), 64'h1);
        send_field(1, 2, 16, 1, 9, -1); idle_n(5);
        ack_hold = 0; idle_n(60);
        chk(wcount - w0 == 4, "R5 start during drain missed", 64'(wcount - w0), 64'd4);
        chk(cur_field === 1'b1, "R3/R8 drained field even", 64'(cur_field), 64'h1);

        // disable during an odd field: it completes, later fields ignored
        w0 = wcount;
        send_field(0, 2, 8, 1, 10, 1); idle_n(60);
        chk(wcount - w0 == 4, "R9 field in progress completes", 64'(wcount - w0), 64'd4);
        chk(cur_field === 1'b0, "R9 odd field completed", 64'(cur_field), 64'h0);
        w0 = wcount;
        send_field(0, 2, 8, 1, 11, -1); idle_n(20);
        chk(wcount == w0, "R9 ignored after disable", 64'(wcount - w0), 64'd0);

        // re-arm restarts alternation at odd
        cap_enable = 1; idle_n(3);
        send_field(1, 1, 8, 1, 12, -1); idle_n(60);
        chk(cur_field === 1'b0, "R3 re-arm starts odd", 64'(cur_field), 64'h0);
        chk(expq.size() == 0, "R1/R2 all expected writes seen", 64'(expq.size()), 64'h0);

        fin = 1;
        summary();
        $finish;
    end
endmodule